// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits right after instruction memory in a simple 64-bit processor. Memory returns a window of up to ten bytes that starts at the program counter. The block splits one instruction out of that window. It returns the opcode and function nibbles, both register selectors and the embedded 64-bit constant. It also returns the instruction length and the address of the next sequential instruction.

Every output depends only on the current inputs, so the block holds no state. It also reports a status code for the instruction:

- normal;
- halt;
- bad address, when memory flagged an error on the fetch;
- bad instruction, when the opcode or the function nibble is not defined.

Whether a register byte and a constant are present depends on the opcode. A register selector value of 0xF means that no register is used.

Top module: `fd_fetch_decode`

## Requirements
- R1: `icode_o` is the upper nibble of window byte 0 and `ifun_o` is its lower nibble. Window byte k occupies bits [8k+7:8k] of `win_i`.
- R2: For opcodes 2, 3, 4, 5, 6, A and B, `ra_o` is the upper nibble of byte 1 and `rb_o` is its lower nibble. For every other opcode, both selectors are 0xF.
- R3: The constant is read little-endian. It starts at byte 2 for opcodes 3, 4 and 5, and at byte 1 for opcodes 7 and 8. For all other opcodes `valc_o` is zero.
- R4: `next_pc_o` equals `pc_i` plus the instruction length, taken modulo 2^64.
- R5: When `mem_err_i` is 1, `stat_o` is 3 (bad address), whatever the opcode.
- R6: When there is no memory error, `stat_o` is 4 (bad instruction) in any of these cases:
  - the opcode is C to F;
  - opcode 2 or 7 has a function nibble above 6;
  - opcode 6 has a function nibble above 3;
  - any other opcode has a nonzero function nibble.
- R7: `stat_o` is 2 (halt) for byte 0 equal to 0x00 when there is no memory error.
- R8: `stat_o` is 1 (normal) for every other valid instruction.
- R9: `len_o` is 1, plus 1 when a register byte is present, plus 8 when a constant is present. It is always between 1 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 64 | Address of the instruction |
| win_i | input | 80 | Fetch window, byte k at bits [8k+7:8k] |
| mem_err_i | input | 1 | Memory reported an error on this fetch |
| icode_o | output | 4 | Opcode nibble |
| ifun_o | output | 4 | Function nibble |
| ra_o | output | 4 | First register selector, 0xF when none |
| rb_o | output | 4 | Second register selector, 0xF when none |
| valc_o | output | 64 | Embedded constant, zero when absent |
| len_o | output | 4 | Instruction length in bytes |
| next_pc_o | output | 64 | Address of the following instruction |
| stat_o | output | 3 | 1 normal, 2 halt, 3 bad address, 4 bad instruction |

## Verification
The bench drives every opcode class through the block:

- **Register only:** push is the case that shows whether the register byte is taken without a constant.
- **Constant only:** jump and call show whether the constant is picked up at byte 1 rather than byte 2.
- **Register and constant:** immediate move and memory moves show the byte-2 offset and a full 10-byte length.

Byte patterns are distinct in every position, so a constant read from the wrong offset or in reversed byte order shows up as a different value.

Invalid function nibbles sit just past each legal range, and opcodes C and F are also tried. Together these separate the bad-instruction checks for each opcode group. A halt opcode with a nonzero function nibble shows that the halt status needs the whole byte to be 0x00.

A memory error combined with an otherwise valid halt shows the status priority. A program counter near the top of the address space shows that the next address wraps.

// File: rtl/fd_pkg.sv
package fd_pkg;
   localparam logic [3:0] OP_HALT  = 4'h0;
   localparam logic [3:0] OP_NOP   = 4'h1;
   localparam logic [3:0] OP_CMOV  = 4'h2;
   localparam logic [3:0] OP_IRMOV = 4'h3;
   localparam logic [3:0] OP_RMMOV = 4'h4;
   localparam logic [3:0] OP_MRMOV = 4'h5;
   localparam logic [3:0] OP_ALU   = 4'h6;
   localparam logic [3:0] OP_JMP   = 4'h7;
   localparam logic [3:0] OP_CALL  = 4'h8;
   localparam logic [3:0] OP_RET   = 4'h9;
   localparam logic [3:0] OP_PUSH  = 4'hA;
   localparam logic [3:0] OP_POP   = 4'hB;

   localparam logic [3:0] REG_NONE = 4'hF;

   typedef enum logic [2:0] {
      ST_AOK = 3'd1,
      ST_HLT = 3'd2,
      ST_ADR = 3'd3,
      ST_INS = 3'd4
   } fd_stat_e;
endpackage

// File: rtl/fd_len_calc.sv
module fd_len_calc
   import fd_pkg::*;
#(
   parameter int WORD_BYTES = 8,
   parameter int LEN_W      = 4
) (
   input  logic [3:0]       icode_i,
   output logic             has_reg_o,
   output logic             has_val_o,
   output logic [LEN_W-1:0] len_o
);
   always_comb begin
      unique case (icode_i)
         OP_CMOV, OP_IRMOV, OP_RMMOV, OP_MRMOV,
         OP_ALU, OP_PUSH, OP_POP: has_reg_o = 1'b1;
         default:                 has_reg_o = 1'b0;
      endcase
      unique case (icode_i)
         OP_IRMOV, OP_RMMOV, OP_MRMOV,
         OP_JMP, OP_CALL:         has_val_o = 1'b1;
         default:                 has_val_o = 1'b0;
      endcase
   end

   assign len_o = LEN_W'(1)
                + (has_reg_o ? LEN_W'(1) : LEN_W'(0))
                + (has_val_o ? LEN_W'(WORD_BYTES) : LEN_W'(0));
endmodule

// File: rtl/fd_field_extract.sv
module fd_field_extract
   import fd_pkg::*;
#(
   parameter int WORD_BYTES = 8,
   parameter int WIN_BYTES  = WORD_BYTES + 2
) (
   input  logic [WIN_BYTES*8-1:0]  win_i,
   input  logic                    has_reg_i,
   input  logic                    has_val_i,
   output logic [3:0]              ra_o,
   output logic [3:0]              rb_o,
   output logic [WORD_BYTES*8-1:0] valc_o
);
   logic [WORD_BYTES*8-1:0] word_b1;
   logic [WORD_BYTES*8-1:0] word_b2;

   for (genvar k = 0; k < WORD_BYTES; k++) begin : g_gather
      assign word_b1[8*k +: 8] = win_i[8*(k+1) +: 8];
      assign word_b2[8*k +: 8] = win_i[8*(k+2) +: 8];
   end

   assign ra_o   = has_reg_i ? win_i[15:12] : REG_NONE;
   assign rb_o   = has_reg_i ? win_i[11:8]  : REG_NONE;
   assign valc_o = !has_val_i ? '0 : (has_reg_i ? word_b2 : word_b1);
endmodule

// File: rtl/fd_stat_gen.sv
module fd_stat_gen
   import fd_pkg::*;
(
   input  logic [3:0] icode_i,
   input  logic [3:0] ifun_i,
   input  logic       mem_err_i,
   output logic [2:0] stat_o
);
   logic fn_ok;

   always_comb begin
      unique case (icode_i)
         OP_CMOV, OP_JMP: fn_ok = (ifun_i <= 4'd6);
         OP_ALU:          fn_ok = (ifun_i <= 4'd3);
         OP_HALT, OP_NOP, OP_IRMOV, OP_RMMOV, OP_MRMOV,
         OP_CALL, OP_RET, OP_PUSH, OP_POP:
                          fn_ok = (ifun_i == 4'd0);
         default:         fn_ok = 1'b0;
      endcase

      if (mem_err_i)             stat_o = ST_ADR;
      else if (!fn_ok)           stat_o = ST_INS;
      else if (icode_i == OP_HALT) stat_o = ST_HLT;
      else                       stat_o = ST_AOK;
   end
endmodule

// File: rtl/fd_fetch_decode.sv
module fd_fetch_decode
   import fd_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int WORD_BYTES = 8,
   localparam int WIN_BYTES = WORD_BYTES + 2,
   localparam int LEN_W     = $clog2(WIN_BYTES + 1)
) (
   input  logic [ADDR_W-1:0]       pc_i,
   input  logic [WIN_BYTES*8-1:0]  win_i,
   input  logic                    mem_err_i,
   output logic [3:0]              icode_o,
   output logic [3:0]              ifun_o,
   output logic [3:0]              ra_o,
   output logic [3:0]              rb_o,
   output logic [WORD_BYTES*8-1:0] valc_o,
   output logic [LEN_W-1:0]        len_o,
   output logic [ADDR_W-1:0]       next_pc_o,
   output logic [2:0]              stat_o
);
   if (WORD_BYTES < 1 || ADDR_W <= LEN_W) begin : g_bad_param
      $error("fd_fetch_decode: unsupported WORD_BYTES/ADDR_W");
   end

   logic has_reg;
   logic has_val;

   assign icode_o = win_i[7:4];
   assign ifun_o  = win_i[3:0];

   fd_len_calc #(.WORD_BYTES(WORD_BYTES), .LEN_W(LEN_W)) u_len (
      .icode_i  (icode_o),
      .has_reg_o(has_reg),
      .has_val_o(has_val),
      .len_o    (len_o)
   );

   fd_field_extract #(.WORD_BYTES(WORD_BYTES), .WIN_BYTES(WIN_BYTES)) u_fields (
      .win_i    (win_i),
      .has_reg_i(has_reg),
      .has_val_i(has_val),
      .ra_o     (ra_o),
      .rb_o     (rb_o),
      .valc_o   (valc_o)
   );

   fd_stat_gen u_stat (
      .icode_i  (icode_o),
      .ifun_i   (ifun_o),
      .mem_err_i(mem_err_i),
      .stat_o   (stat_o)
   );

   assign next_pc_o = pc_i + {{(ADDR_W-LEN_W){1'b0}}, len_o};
endmodule

// File: rtl/fd_fetch_decode_chk.sv
module fd_fetch_decode_chk
   import fd_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int WORD_BYTES = 8,
   parameter int LEN_W      = 4
) (
   input logic [ADDR_W-1:0]       pc_i,
   input logic                    mem_err_i,
   input logic [3:0]              icode_o,
   input logic [3:0]              ra_o,
   input logic [3:0]              rb_o,
   input logic [WORD_BYTES*8-1:0] valc_o,
   input logic [LEN_W-1:0]        len_o,
   input logic [ADDR_W-1:0]       next_pc_o,
   input logic [2:0]              stat_o
);
   always_comb begin
      AST_LEN_RANGE: assert (len_o >= LEN_W'(1) && len_o <= LEN_W'(WORD_BYTES + 2)); // R9
      AST_NEXT_PC: assert (next_pc_o == pc_i + {{(ADDR_W-LEN_W){1'b0}}, len_o}); // R4
      AST_ADR_FIRST: assert (!mem_err_i || stat_o == ST_ADR); // R5
      AST_NOREG_NONE: assert (len_o[0] == 1'b0 || (ra_o == REG_NONE && rb_o == REG_NONE)); // R2
      AST_NOVAL_ZERO: assert (len_o > LEN_W'(2) || valc_o == '0); // R3
      AST_HALT_CODE: assert (stat_o != ST_HLT || icode_o == OP_HALT); // R7
   end
endmodule

bind fd_fetch_decode fd_fetch_decode_chk #(
   .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .LEN_W(LEN_W)
) u_chk (
   .pc_i(pc_i), .mem_err_i(mem_err_i), .icode_o(icode_o), .ra_o(ra_o),
   .rb_o(rb_o), .valc_o(valc_o), .len_o(len_o), .next_pc_o(next_pc_o),
   .stat_o(stat_o)
);

// File: tb/fd_fetch_decode_tb_top.sv
module fd_fetch_decode_tb_top;
   typedef struct {
      logic [3:0]  icode, ifun, ra, rb;
      logic [63:0] valc, npc;
      logic [3:0]  len;
      logic [2:0]  stat;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] pc;
   logic [79:0] win;
   logic        merr;
   logic [3:0]  icode, ifun, ra, rb, len;
   logic [63:0] valc, npc;
   logic [2:0]  stat;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   exp_t q[$];

   always #5 clk = ~clk;

   fd_fetch_decode dut_i (
      .pc_i(pc), .win_i(win), .mem_err_i(merr), .icode_o(icode), .ifun_o(ifun),
      .ra_o(ra), .rb_o(rb), .valc_o(valc), .len_o(len), .next_pc_o(npc),
      .stat_o(stat)
   );

   // Expected values from the requirements
   function automatic exp_t model(input logic [63:0] p, input logic [79:0] w, input logic me);
      exp_t e;
      logic hr, hv, ok;
      e.icode = w[7:4];                                       // R1
      e.ifun  = w[3:0];
      hr = e.icode inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB};
      hv = e.icode inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8};
      e.ra = hr ? w[15:12] : 4'hF;                            // R2
      e.rb = hr ? w[11:8]  : 4'hF;
      e.valc = 64'd0;                                         // R3
      if (hv) for (int k = 0; k < 8; k++)
         e.valc[8*k +: 8] = hr ? w[8*(k+2) +: 8] : w[8*(k+1) +: 8];
      e.len = 4'd1 + (hr ? 4'd1 : 4'd0) + (hv ? 4'd8 : 4'd0); // R9
      e.npc = p + 64'(e.len);                                 // R4
      case (e.icode)
         4'h2, 4'h7: ok = e.ifun <= 4'd6;
         4'h6:       ok = e.ifun <= 4'd3;
         4'hC, 4'hD, 4'hE, 4'hF: ok = 1'b0;
         default:    ok = e.ifun == 4'd0;
      endcase
      if (me)                 e.stat = 3'd3;                  // R5
      else if (!ok)           e.stat = 3'd4;                  // R6
      else if (e.icode == 0)  e.stat = 3'd2;                  // R7
      else                    e.stat = 3'd1;                  // R8
      return e;
   endfunction

   task automatic chk(input string tag, input string f, input logic [63:0] a, input logic [63:0] x);
      checks++;
      if (a !== x) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h", tag, f, a, x);
      end
   endtask

   task automatic drive(input logic [63:0] p, input logic [79:0] w, input logic me);
      @(posedge clk);
      pc = p; win = w; merr = me;
      q.push_back(model(p, w, me));
   endtask

   // Monitor: compare at the falling edge, away from input changes
   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk("R1", "icode", 64'(icode), 64'(e.icode));
         chk("R1", "ifun",  64'(ifun),  64'(e.ifun));
         chk("R2", "ra",    64'(ra),    64'(e.ra));
         chk("R2", "rb",    64'(rb),    64'(e.rb));
         chk("R3", "valc",  valc,       e.valc);
         chk("R9", "len",   64'(len),   64'(e.len));
         chk("R4", "npc",   npc,        e.npc);
         chk(e.stat == 3 ? "R5" : e.stat == 4 ? "R6" : e.stat == 2 ? "R7" : "R8",
             "stat", 64'(stat), 64'(e.stat));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         errors++;
         $display("FAIL watchdog act=%0d exp=<5000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   localparam logic [63:0] K = 64'h8877_6655_4433_2211;

   initial begin
      pc = 64'h0; win = '0; merr = 1'b0;
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      drive(64'h0, 80'h0, 1'b0);                              // idle/all-zero: R7 halt
      drive(64'h100, 80'h05, 1'b0);                           // halt with fn!=0: R6
      drive(64'h100, 80'h10, 1'b0);                           // nop: R8
      drive(64'h200, {64'h0, 8'h4C, 8'h26}, 1'b0);            // cmov fn6: R2
      drive(64'h200, {64'h0, 8'h4C, 8'h27}, 1'b0);            // cmov fn7: R6
      drive(64'h300, {K, 8'hF3, 8'h30}, 1'b0);                // irmov: R3 byte 2
      drive(64'h300, {K, 8'h12, 8'h40}, 1'b0);                // rmmov
      drive(64'h300, {K, 8'h21, 8'h50}, 1'b0);                // mrmov
      drive(64'h400, {64'h0, 8'h01, 8'h63}, 1'b0);            // OP fn3: R8
      drive(64'h400, {64'h0, 8'h01, 8'h64}, 1'b0);            // OP fn4: R6
      drive(64'h500, {8'hEE, K, 8'h76}, 1'b0);                // jXX fn6: R3 byte 1
      drive(64'h500, {8'hEE, K, 8'h77}, 1'b0);                // jXX fn7: R6
      drive(64'h600, {8'hDD, K, 8'h80}, 1'b0);                // call
      drive(64'h600, {72'hFF_FFFF, 8'h90}, 1'b0);             // ret
      drive(64'h700, {64'hAB, 8'h2F, 8'hA0}, 1'b0);           // push
      drive(64'h700, {64'hAB, 8'h7F, 8'hB0}, 1'b0);           // pop
      drive(64'h800, 80'hC0, 1'b0);                           // code C: R6
      drive(64'h800, 80'hF0, 1'b0);                           // code F: R6
      drive(64'h900, 80'h00, 1'b1);                           // halt + memerr: R5
      drive(64'h900, 80'hF0, 1'b1);                           // bad + memerr: R5
      drive(64'hFFFF_FFFF_FFFF_FFF8, {K, 8'h01, 8'h30}, 1'b0); // wrap: R4
      drive(64'hFFFF_FFFF_FFFF_FFFF, 80'h10, 1'b0);           // wrap by 1: R4
      while (q.size() > 0) @(posedge clk);
      @(posedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule